// File: doc/BRIEF.md
# Freezable Event Counter Bank

A bank of eleven event counters for observing a memory controller's activity, reached through a simple 32-bit register port. Counter 0 is 64 bits wide and advances on every clock cycle. Counters 1 to 10 are 32 bits wide. Each of them picks one line of a shared event input bus through a 7-bit event code and advances by one in each cycle in which that line is high.

Counting is gated at two levels. A global freeze bit stops the whole bank, and a freeze bit in each counter's control word stops that counter alone. The global freeze overrides the local bits. A counter overflows when an increment moves its top bit from 0 to 1. If the global interrupt enable, the global freeze-on-condition enable and the counter's own condition enable are all set, the hardware sets the global freeze bit in that same cycle, so every counter stops. While any enabled counter holds its top bit, the level interrupt output stays high.

Software reads the counts, clears the top bit of the counter that overflowed by writing its count register, and writes the global freeze bit back to 0 to resume counting. The bus port is single-cycle: a write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from the addressed register.

Top module: `evctr_bank`

## Requirements
- R1: After reset the global control word (0x40) reads 0x8000_0000 (bank frozen, both enables off). Every control word and every count reads 0, and `irq_o` is low.
- R2: A counter n in 1..10 advances by exactly one at each clock edge where it is unfrozen and `evt_in[code]` is high. The code is bits 22:16 of its control A word. With 16 event lines, codes 16 and above never count.
- R3: Counter 0 advances on every unfrozen clock edge as one 64-bit value. Its low word is at 0x58 and its high word at 0x5C, and a carry passes from the low word into the high word.
- R4: A counter advances only while both the global freeze (0x40 bit 31) and its own freeze (control A bit 31) are 0. A set global freeze stops a counter whose local freeze is 0.
- R5: A write to a count register loads the written value, so writing 0 clears it. A write in the same cycle as an increment wins over the increment.
- R6: When an increment moves a counter's top bit from 0 to 1 while 0x40 bit 30 (interrupt enable), 0x40 bit 29 (freeze on condition) and the counter's control A bit 26 (condition enable) are all 1, 0x40 bit 31 is set at that same edge. All counters then hold, with the overflowing counter keeping its top-bit-set value.
- R7: `irq_o` is high exactly while 0x40 bits 30 and 29 are both 1 and some counter with control A bit 26 set has its top bit set. Writing that count to 0 drops `irq_o`, and writing 0x40 bit 31 to 0 resumes counting.
- R8: An overflow that happens while any one of the three enables is 0 does not freeze the bank, and the counter keeps advancing past its top bit.
- R9: Control B of each counter (0x54 + 0x10·n) stores all 32 written bits and reads them back. It has no effect on counting.
- R10: Control A of counter n is at 0x50 + 0x10·n. It keeps only bits 31, 26 and 22:16. In the global word only bits 31:29 are kept. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_in | input | 16 | Event lines selectable by counters 1 to 10 |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The embedded assertions check the following on every cycle:
- a frozen counter holds its value unless software writes it;
- no counter moves by more than one per cycle without a write;
- a qualified top-bit rise is always followed by the global freeze;
- `irq_o` never rises without both global enables.

Only the bench's scenarios can show the rest: that a counter follows the event line chosen by its code, that out-of-range codes stay silent, and that the cycle counter carries into its high word. The same applies to the exact number of increments between an unfreeze and a freeze, to a count write winning over a simultaneous increment, and to counting resuming after software clears an overflow.

// File: rtl/evctr_bank.sv
module evctr_bank #(
  parameter int NUM_CTR = 11,
  parameter int DW      = 32,
  parameter int EV_NUM  = 16,
  parameter int SEL_W   = 7,
  parameter int AW      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [EV_NUM-1:0] evt_in,
  output logic              irq_o
);
  localparam logic [AW-1:0] GCTL_ADDR = AW'('h40);
  localparam logic [AW-1:0] BANK_BASE = AW'('h50);
  localparam int IDX_W   = AW - 4;
  localparam int EVI_W   = $clog2(EV_NUM);
  localparam int FRZ_BIT = 31;
  localparam int IE_BIT  = 30;
  localparam int FCE_BIT = 29;
  localparam int CE_BIT  = 26;
  localparam int EVT_LSB = 16;

  logic g_frz, g_ie, g_fce;
  logic [NUM_CTR-1:0] l_frz, l_ce;
  logic [SEL_W-1:0] l_evt [NUM_CTR];
  logic [DW-1:0] l_b [NUM_CTR];
  logic [DW-1:0] cnt [NUM_CTR];
  logic [DW-1:0] cyc_hi;

  logic [AW-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [1:0] sub;
  logic wr, g_wr, bank_hit, wh;
  logic [NUM_CTR-1:0] wa, wb, wc, wany, inc, msb, ovf_hit;
  logic trip;

  assign off      = bus_addr - BANK_BASE;
  assign idx      = off[AW-1:4];
  assign sub      = off[3:2];
  assign wr       = bus_sel && bus_wr;
  assign g_wr     = wr && (bus_addr == GCTL_ADDR);
  assign bank_hit = (bus_addr >= BANK_BASE) && (int'(idx) < NUM_CTR);

  always_comb begin
    wa = '0; wb = '0; wc = '0; wh = 1'b0;
    if (wr && bank_hit) begin
      case (sub)
        2'd0: wa[idx] = 1'b1;
        2'd1: wb[idx] = 1'b1;
        2'd2: wc[idx] = 1'b1;
        default: wh = (idx == '0);
      endcase
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    logic run;
    assign run = !g_frz && !l_frz[n];
    if (n == 0) begin : g_cyc
      assign inc[n]     = run;
      assign msb[n]     = cyc_hi[DW-1];
      assign wany[n]    = wc[n] || wh;
      assign ovf_hit[n] = inc[n] && !wany[n] && ({cyc_hi, cnt[n]} == {1'b0, {(2*DW-1){1'b1}}});
    end else begin : g_evt
      logic evt_hit;
      assign evt_hit    = (int'(l_evt[n]) < EV_NUM) && evt_in[l_evt[n][EVI_W-1:0]];
      assign inc[n]     = run && evt_hit;
      assign msb[n]     = cnt[n][DW-1];
      assign wany[n]    = wc[n];
      assign ovf_hit[n] = inc[n] && !wany[n] && (cnt[n] == {1'b0, {(DW-1){1'b1}}});
    end
  end

  assign trip  = g_ie && g_fce && |(ovf_hit & l_ce);
  assign irq_o = g_ie && g_fce && |(msb & l_ce);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_frz  <= 1'b1;
      g_ie   <= 1'b0;
      g_fce  <= 1'b0;
      l_frz  <= '0;
      l_ce   <= '0;
      cyc_hi <= '0;
      for (int n = 0; n < NUM_CTR; n++) begin
        l_evt[n] <= '0;
        l_b[n]   <= '0;
        cnt[n]   <= '0;
      end
    end else begin
      if (trip)      g_frz <= 1'b1;
      else if (g_wr) g_frz <= bus_wdata[FRZ_BIT];
      if (g_wr) begin
        g_ie  <= bus_wdata[IE_BIT];
        g_fce <= bus_wdata[FCE_BIT];
      end
      for (int n = 0; n < NUM_CTR; n++) begin
        if (wa[n]) begin
          l_frz[n] <= bus_wdata[FRZ_BIT];
          l_ce[n]  <= bus_wdata[CE_BIT];
          l_evt[n] <= bus_wdata[EVT_LSB +: SEL_W];
        end
        if (wb[n]) l_b[n] <= bus_wdata;
      end
      if (wc[0])       cnt[0] <= bus_wdata;
      else if (wh)     cyc_hi <= bus_wdata;
      else if (inc[0]) {cyc_hi, cnt[0]} <= {cyc_hi, cnt[0]} + 1'b1;
      for (int n = 1; n < NUM_CTR; n++) begin
        if (wc[n])       cnt[n] <= bus_wdata;
        else if (inc[n]) cnt[n] <= cnt[n] + 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == GCTL_ADDR) begin
      bus_rdata[FRZ_BIT] = g_frz;
      bus_rdata[IE_BIT]  = g_ie;
      bus_rdata[FCE_BIT] = g_fce;
    end else if (bank_hit) begin
      case (sub)
        2'd0: begin
          bus_rdata[FRZ_BIT]             = l_frz[idx];
          bus_rdata[CE_BIT]              = l_ce[idx];
          bus_rdata[EVT_LSB +: SEL_W]    = l_evt[idx];
        end
        2'd1:    bus_rdata = l_b[idx];
        2'd2:    bus_rdata = cnt[idx];
        default: bus_rdata = (idx == '0) ? cyc_hi : '0;
      endcase
    end
  end

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_chk
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(g_frz) || $past(l_frz[n])) && !$past(wany[n]) |-> cnt[n] == $past(cnt[n])); // R4
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wany[n]) |-> (cnt[n] - $past(cnt[n])) <= DW'(1)); // R2
    AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(g_ie && g_fce && l_ce[n] && !msb[n] && !wany[n]) && msb[n] |-> g_frz); // R6
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> g_ie && g_fce); // R7
endmodule

// File: tb/evctr_bank_tb_top.sv
module evctr_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_in = '0;
  logic irq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evctr_bank dut_i (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_o(irq_o));

  localparam logic [7:0] G = 8'h40;
  localparam logic [31:0] FRZ = 32'h8000_0000;
  localparam logic [31:0] ENS = 32'h6000_0000;
  localparam logic [31:0] CE  = 32'h0400_0000;

  typedef struct packed {
    logic [3:0]  c;
    logic [6:0]  code;
    logic [15:0] pat;
    logic [7:0]  idle;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{4'd1,  7'd0,   16'h0001, 8'd3, 32'd4},
    '{4'd2,  7'd5,   16'h0020, 8'd0, 32'd1},
    '{4'd7,  7'd15,  16'h8000, 8'd6, 32'd7},
    '{4'd4,  7'd2,   16'hFFFB, 8'd5, 32'd0},
    '{4'd10, 7'd100, 16'hFFFF, 8'd4, 32'd0},
    '{4'd0,  7'd0,   16'h0000, 8'd9, 32'd10}
  };

  function automatic logic [7:0] aA(input int n); return 8'h50 + 8'(n * 16); endfunction
  function automatic logic [7:0] aB(input int n); return 8'h54 + 8'(n * 16); endfunction
  function automatic logic [7:0] aC(input int n); return 8'h58 + 8'(n * 16); endfunction
  localparam logic [7:0] HI0 = 8'h5C;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk_rd("R1 global", G, FRZ);
    chk_rd("R1 ctrlA", aA(3), 32'h0);
    chk_rd("R1 count", aC(5), 32'h0);
    chk_rd("R1 cyc hi", HI0, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);

    // R10 field layout
    wr(aA(6), 32'hFFFF_FFFF);
    chk_rd("R10 ctrlA bits", aA(6), 32'h847F_0000);
    wr(aA(6), 32'h0);
    wr(G, 32'hFFFF_FFFF);
    chk_rd("R10 global bits", G, 32'hE000_0000);
    wr(G, FRZ);

    // R2 R3 vector table
    foreach (VEC[i]) begin
      wr(G, FRZ);
      wr(aA(int'(VEC[i].c)), {9'h0, VEC[i].code, 16'h0});
      wr(aC(int'(VEC[i].c)), 32'h0);
      if (VEC[i].c == 0) wr(HI0, 32'h0);
      evt_in = VEC[i].pat;
      wr(G, 32'h0);
      idle(int'(VEC[i].idle));
      wr(G, FRZ);
      chk_rd(VEC[i].c == 0 ? "R3 table" : "R2 table", aC(int'(VEC[i].c)), VEC[i].exp);
    end

    // R9 control B stored, no effect
    wr(aB(2), 32'hA5A5_0F0F);
    chk_rd("R9 readback", aB(2), 32'hA5A5_0F0F);
    wr(aA(2), 32'h0001_0000);
    wr(aC(2), 32'h0);
    evt_in = 16'h0002;
    wr(G, 32'h0); idle(2); wr(G, FRZ);
    chk_rd("R9 count unaffected", aC(2), 32'd3);

    // R4 local and global freeze
    wr(aA(5), FRZ);
    wr(aA(6), 32'h0);
    wr(aC(5), 32'h0);
    wr(aC(6), 32'h0);
    evt_in = 16'h0001;
    wr(G, 32'h0); idle(3); wr(G, FRZ);
    chk_rd("R4 local frozen", aC(5), 32'd0);
    chk_rd("R4 local running", aC(6), 32'd4);
    idle(5);
    chk_rd("R4 global overrides", aC(6), 32'd4);
    wr(aA(5), 32'h0);

    // R5 write beats increment
    wr(aA(8), 32'h0);
    wr(aC(8), 32'h0);
    wr(G, 32'h0);
    wr(aC(8), 32'h100);
    idle(2);
    wr(G, FRZ);
    chk_rd("R5 write priority", aC(8), 32'h103);
    wr(aC(8), 32'h0);
    chk_rd("R5 clear", aC(8), 32'h0);

    // R3 carry into high word
    wr(aA(0), 32'h0);
    wr(aC(0), 32'hFFFF_FFFE);
    wr(HI0, 32'h1);
    wr(G, 32'h0); idle(2); wr(G, FRZ);
    chk_rd("R3 low word", aC(0), 32'h1);
    chk_rd("R3 high word", HI0, 32'h2);
    wr(aC(0), 32'h0); wr(HI0, 32'h0);

    // R6 R7 overflow freeze and interrupt
    wr(aA(3), CE);
    wr(aC(3), 32'h7FFF_FFFE);
    wr(aA(4), 32'h0);
    wr(aC(4), 32'h0);
    evt_in = 16'h0001;
    wr(G, ENS);
    idle(5);
    chk_rd("R6 global frozen", G, 32'hE000_0000);
    chk_rd("R6 held value", aC(3), 32'h8000_0000);
    chk_rd("R6 others stop", aC(4), 32'd2);
    chk("R7 irq high", {31'h0, irq_o}, 32'h1);
    wr(aC(3), 32'h0);
    chk("R7 irq cleared", {31'h0, irq_o}, 32'h0);
    wr(G, ENS); idle(2); wr(G, FRZ | ENS);
    chk_rd("R7 resumed", aC(3), 32'd3);

    // R8 missing condition enable
    wr(aA(3), 32'h0);
    wr(aC(3), 32'h7FFF_FFFF);
    wr(G, ENS); idle(3);
    chk("R8 no irq ce=0", {31'h0, irq_o}, 32'h0);
    wr(G, FRZ);
    chk_rd("R8 kept counting ce=0", aC(3), 32'h8000_0003);
    // R8 missing interrupt enable
    wr(aA(3), CE);
    wr(aC(3), 32'h7FFF_FFFF);
    wr(G, 32'h2000_0000); idle(3);
    chk("R8 no irq ie=0", {31'h0, irq_o}, 32'h0);
    wr(G, FRZ);
    chk_rd("R8 kept counting ie=0", aC(3), 32'h8000_0003);
    wr(aA(3), 32'h0);
    wr(aC(3), 32'h0);

    // R6 cycle counter overflow
    wr(aC(0), 32'hFFFF_FFFF);
    wr(HI0, 32'h7FFF_FFFF);
    wr(aA(0), CE);
    wr(G, ENS); idle(3);
    chk_rd("R6 c0 high", HI0, 32'h8000_0000);
    chk_rd("R6 c0 low", aC(0), 32'h0);
    chk_rd("R6 c0 froze bank", G, 32'hE000_0000);
    wr(aA(0), 32'h0);
    wr(HI0, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule